// File: doc/BRIEF.md
# Keypad Row/Column Scanner with Two-Edge Debounce

This block connects a telephone-style keypad of five rows and four columns to the dialling logic. At rest it drives every row high and just watches the column lines. It does not scan all the time. When a column becomes active and stays active long enough, it steps a single driven row down the matrix to find which contact is closed. If exactly one contact is found, it reports a key code with a one-cycle press strobe.

After a scan, the block returns to driving every row and waits until the keypad has been quiet for the same debounce interval. Only then does it report the release and start sensing again. If two or more keys are closed together, the entry is rejected and no event is produced. Rows 0 to 3 carry the sixteen dial keys. Row 4 carries the four function keys.

A low chip-enable puts the block in standby. In standby the rows are released and keypad activity is ignored. A short standby leaves the block exactly where it was. A standby that lasts long enough resets the block's internal state.

Top module: `keypad_scanner`

## Requirements
- R1: With chipEn high and no scan in progress, all rows are driven high. The key code is row*4+column. Rows are numbered 0 (top) to 4. Bit c of colIn is column c. Row 4 holds the function keys, codes 16 to 19.
- R2: A scan starts only after colIn has been nonzero and identical for DEBOUNCE consecutive clock samples. If the pattern changes earlier, the block goes back to sensing and no event is produced.
- R3: During a scan, one row is driven per cycle (rowOut = 1<<r), for r = 0 up to NUM_ROWS-1 in order.
- R4: keyPress is high for exactly one cycle, in the cycle after the last row has been scanned, when exactly one contact was seen. In that same cycle keyCode holds the new code.
- R5: If two or more contacts are seen during a scan, there is no keyPress, no later keyRelease, and keyCode is left unchanged.
- R6: After a scan, all rows are driven high. No further scan starts until colIn has read zero for DEBOUNCE consecutive samples. Any nonzero sample restarts this count.
- R7: keyRelease is high for one cycle when the release count completes, but only if the entry was valid. It is never high in the same cycle as keyPress.
- R8: While chipEn is low, rowOut is all zero, colIn is ignored, no events are produced and the scan state is frozen.
- R9: A chipEn-low interval of fewer than RST_DELAY samples has no effect. Operation resumes from the point where it stopped.
- R10: At the RST_DELAY-th consecutive low sample of chipEn, the block resets internally. It returns to sensing, keyCode becomes 0, and any pending release is dropped.
- R11: While rstN is low, keyPress and keyRelease are 0, keyCode is 0 and the block is sensing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEn | input | 1 | High for operation, low for standby |
| colIn | input | NUM_COLS | Column sense lines, 1 = contact to a driven row |
| rowOut | output | NUM_ROWS | Row drive lines, 1 = driven |
| keyPress | output | 1 | One-cycle strobe for a valid key entry |
| keyRelease | output | 1 | One-cycle strobe when a valid key is released |
| keyCode | output | CODE_W | Code of the last valid key |

## Verification
Several input patterns are applied. Single taps on a dial key and on a function key confirm the code arithmetic and the pairing of press and release. Pairs of keys, one pair in a shared column and one pair in a shared row, check that the block tells a clean entry from ambiguous contacts. Short contact bursts during the press count and during the release count check that each edge is debounced on its own. Standby intervals just below and above the reset delay check that a brief chip-enable drop is harmless and that a long one clears the block.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef enum logic [1:0] {
    ST_SENSE = 2'd0,
    ST_PDEB  = 2'd1,
    ST_SCAN  = 2'd2,
    ST_HOLD  = 2'd3
  } scanState_t;

  typedef struct packed {
    logic loadRef;
    logic clearScan;
    logic accumulate;
    logic finishScan;
    logic fireRelease;
    logic wipe;
  } ctlStrobe_t;

endpackage

// File: rtl/kpd_ctrl.sv
module kpd_ctrl
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS  = 5,
  parameter int DEBOUNCE  = 8,
  parameter int RST_DELAY = 16,
  parameter int ROW_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipEn,
  input  logic                colAny,
  input  logic                colSame,
  output logic [NUM_ROWS-1:0] rowOut,
  output logic [ROW_W-1:0]    rowIdx,
  output ctlStrobe_t          strobe
);

  localparam int CNT_W = $clog2(DEBOUNCE + 1);
  localparam int CE_W  = $clog2(RST_DELAY + 1);
  localparam logic [CNT_W-1:0] DEB_LAST  = CNT_W'(DEBOUNCE - 1);
  localparam logic [CE_W-1:0]  CE_LAST   = CE_W'(RST_DELAY - 1);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(NUM_ROWS - 1);

  scanState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [ROW_W-1:0] rowNext;
  logic [CE_W-1:0]  ceCnt;
  logic             standbyHit;

  assign standbyHit = !chipEn && (ceCnt == CE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceCnt <= '0;
    end else if (chipEn) begin
      ceCnt <= '0;
    end else if (ceCnt != CE_LAST) begin
      ceCnt <= ceCnt + 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    rowNext   = rowIdx;
    strobe    = '0;
    if (!chipEn) begin
      if (standbyHit) begin
        strobe.wipe = 1'b1;
        stateNext   = ST_SENSE;
        cntNext     = '0;
        rowNext     = '0;
      end
    end else begin
      unique case (state)
        ST_SENSE: begin
          if (colAny) begin
            strobe.loadRef = 1'b1;
            stateNext      = ST_PDEB;
            cntNext        = CNT_W'(1);
          end
        end
        ST_PDEB: begin
          if (!colSame) begin
            stateNext = ST_SENSE;
            cntNext   = '0;
          end else if (cnt == DEB_LAST) begin
            strobe.clearScan = 1'b1;
            stateNext        = ST_SCAN;
            rowNext          = '0;
            cntNext          = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_SCAN: begin
          strobe.accumulate = 1'b1;
          if (rowIdx == ROW_LAST) begin
            strobe.finishScan = 1'b1;
            stateNext         = ST_HOLD;
            cntNext           = '0;
          end else begin
            rowNext = rowIdx + 1'b1;
          end
        end
        ST_HOLD: begin
          if (colAny) begin
            cntNext = '0;
          end else if (cnt == DEB_LAST) begin
            strobe.fireRelease = 1'b1;
            stateNext          = ST_SENSE;
            cntNext            = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: stateNext = ST_SENSE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_SENSE;
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      rowIdx <= rowNext;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowDrive
    assign rowOut[r] = chipEn && ((state != ST_SCAN) || (rowIdx == ROW_W'(r)));
  end

endmodule

// File: rtl/kpd_datapath.sv
module kpd_datapath
  import kpd_pkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int CODE_W   = 5,
  parameter int ROW_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COLS-1:0] colIn,
  input  logic [ROW_W-1:0]    rowIdx,
  input  ctlStrobe_t          strobe,
  output logic                colAny,
  output logic                colSame,
  output logic                keyPress,
  output logic                keyRelease,
  output logic [CODE_W-1:0]   keyCode
);

  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

  logic [NUM_COLS-1:0] colRef;
  logic [1:0]          hits, hitsNext, rowHits;
  logic [COL_W-1:0]    colPos;
  logic [CODE_W-1:0]   rowCode, codeHold, codeFinal;
  logic                validReg;
  logic                single;

  assign colAny  = |colIn;
  assign colSame = colAny && (colIn == colRef);

  always_comb begin
    rowHits = 2'd0;
    colPos  = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (colIn[c]) begin
        colPos = COL_W'(c);
        if (rowHits != 2'd2) rowHits = rowHits + 2'd1;
      end
    end
  end

  assign rowCode   = CODE_W'(int'(rowIdx) * NUM_COLS + int'(colPos));
  assign hitsNext  = (int'(hits) + int'(rowHits) >= 2) ? 2'd2 : (hits + rowHits);
  assign single    = (hitsNext == 2'd1);
  assign codeFinal = (rowHits == 2'd1) ? rowCode : codeHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colRef     <= '0;
      hits       <= '0;
      codeHold   <= '0;
      validReg   <= 1'b0;
      keyPress   <= 1'b0;
      keyRelease <= 1'b0;
      keyCode    <= '0;
    end else begin
      keyPress   <= 1'b0;
      keyRelease <= 1'b0;
      if (strobe.wipe) begin
        colRef   <= '0;
        hits     <= '0;
        codeHold <= '0;
        validReg <= 1'b0;
        keyCode  <= '0;
      end
      if (strobe.loadRef) colRef <= colIn;
      if (strobe.clearScan) begin
        hits     <= '0;
        codeHold <= '0;
      end
      if (strobe.accumulate) begin
        hits <= hitsNext;
        if (rowHits == 2'd1) codeHold <= rowCode;
      end
      if (strobe.finishScan) begin
        keyPress <= single;
        validReg <= single;
        if (single) keyCode <= codeFinal;
      end
      if (strobe.fireRelease) begin
        keyRelease <= validReg;
        validReg   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS  = 5,
  parameter int NUM_COLS  = 4,
  parameter int DEBOUNCE  = 8,
  parameter int RST_DELAY = 16,
  localparam int CODE_W   = $clog2(NUM_ROWS * NUM_COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipEn,
  input  logic [NUM_COLS-1:0] colIn,
  output logic [NUM_ROWS-1:0] rowOut,
  output logic                keyPress,
  output logic                keyRelease,
  output logic [CODE_W-1:0]   keyCode
);

  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  ctlStrobe_t       strobe;
  logic [ROW_W-1:0] rowIdx;
  logic             colAny, colSame;

  kpd_ctrl #(
    .NUM_ROWS (NUM_ROWS),
    .DEBOUNCE (DEBOUNCE),
    .RST_DELAY(RST_DELAY),
    .ROW_W    (ROW_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .chipEn (chipEn),
    .colAny (colAny),
    .colSame(colSame),
    .rowOut (rowOut),
    .rowIdx (rowIdx),
    .strobe (strobe)
  );

  kpd_datapath #(
    .NUM_COLS(NUM_COLS),
    .CODE_W  (CODE_W),
    .ROW_W   (ROW_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .colIn     (colIn),
    .rowIdx    (rowIdx),
    .strobe    (strobe),
    .colAny    (colAny),
    .colSame   (colSame),
    .keyPress  (keyPress),
    .keyRelease(keyRelease),
    .keyCode   (keyCode)
  );

endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 4,
  parameter int CODE_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                chipEn,
  input logic [NUM_COLS-1:0] colIn,
  input logic [NUM_ROWS-1:0] rowOut,
  input logic                keyPress,
  input logic                keyRelease,
  input logic [CODE_W-1:0]   keyCode
);

  localparam logic [NUM_ROWS-1:0] ALL_ROWS = {NUM_ROWS{1'b1}};
  localparam logic [NUM_ROWS-1:0] LAST_ROW = ALL_ROWS ^ (ALL_ROWS >> 1);

  AST_ROWS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    chipEn |-> (rowOut == ALL_ROWS || $countones(rowOut) == 1)); // R1

  AST_SCAN_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && $countones(rowOut) == 1 && !rowOut[NUM_ROWS-1]) |=>
      (!chipEn || rowOut == ($past(rowOut) << 1))); // R3

  AST_PRESS_AFTER_LAST_ROW: assert property (@(posedge clk) disable iff (!rstN)
    keyPress |-> ($past(rowOut) == LAST_ROW)); // R4

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!keyPress && $past(chipEn)) |-> $stable(keyCode)); // R5

  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    keyRelease |-> ($past(colIn) == '0)); // R6

  AST_EVENTS_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(keyPress && keyRelease)); // R7

  AST_STANDBY_ROWS: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> (rowOut == '0)); // R8

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> (!keyPress && !keyRelease)); // R8

endmodule

bind keypad_scanner keypad_scanner_chk #(
  .NUM_ROWS(NUM_ROWS),
  .NUM_COLS(NUM_COLS),
  .CODE_W  (CODE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chipEn    (chipEn),
  .colIn     (colIn),
  .rowOut    (rowOut),
  .keyPress  (keyPress),
  .keyRelease(keyRelease),
  .keyCode   (keyCode)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 5;
  localparam int COLS = 4;
  localparam int DEB  = 8;
  localparam int RSTD = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            chipEn = 1'b1;
  logic [COLS-1:0] colIn;
  logic [ROWS-1:0] rowOut;
  logic            keyPress, keyRelease;
  logic [4:0]      keyCode;
  logic [ROWS*COLS-1:0] pressed = '0;

  int checks = 0;
  int errors = 0;
  int pressSeen = 0;
  int relSeen = 0;

  // reference model state
  int mPh = 0, mCnt = 0, mRow = 0, mHits = 0, mTmp = 0, mCode = 0, mCe = 0;
  int mValid = 0, mPress = 0, mRel = 0;
  logic [COLS-1:0] mRef = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_scanner uut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .colIn(colIn), .rowOut(rowOut),
    .keyPress(keyPress), .keyRelease(keyRelease), .keyCode(keyCode)
  );

  // keypad: a closed key connects its row drive to its column line
  always_comb begin
    colIn = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (pressed[r*COLS+c] && rowOut[r]) colIn[c] = 1'b1;
  end

  function automatic logic [ROWS-1:0] expRows();
    if (!chipEn) return '0;
    if (mPh == 2) return ROWS'(1) << mRow;
    return '1;
  endfunction

  function automatic logic [COLS-1:0] modelCols(logic [ROWS-1:0] rows);
    logic [COLS-1:0] v = '0;
    for (int k = 0; k < ROWS*COLS; k++)
      if (pressed[k] && rows[k/COLS]) v[k%COLS] = 1'b1;
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mRow = 0; mHits = 0; mTmp = 0; mCode = 0;
      mCe = 0; mValid = 0; mPress = 0; mRel = 0; mRef = '0;
    end else begin
      logic [COLS-1:0] cv;
      int n, pos;
      mPress = 0; mRel = 0;
      cv = modelCols(expRows());
      if (!chipEn) begin
        if (mCe == RSTD-1) begin
          mPh = 0; mCnt = 0; mRow = 0; mHits = 0; mTmp = 0;
          mCode = 0; mValid = 0; mRef = '0;
        end else mCe++;
      end else begin
        mCe = 0;
        case (mPh)
          0: if (cv != 0) begin mRef = cv; mPh = 1; mCnt = 1; end
          1: if (cv != mRef) begin mPh = 0; mCnt = 0; end
             else if (mCnt == DEB-1) begin mPh = 2; mRow = 0; mHits = 0; mTmp = 0; mCnt = 0; end
             else mCnt++;
          2: begin
            n = 0; pos = 0;
            for (int c = 0; c < COLS; c++)
              if (pressed[mRow*COLS+c]) begin n++; pos = mRow*COLS+c; end
            mHits += n;
            if (n == 1) mTmp = pos;
            if (mRow == ROWS-1) begin
              mPh = 3; mCnt = 0;
              mValid = (mHits == 1);
              if (mHits == 1) begin mPress = 1; mCode = mTmp; end
            end else mRow++;
          end
          default: if (cv != 0) mCnt = 0;
             else if (mCnt == DEB-1) begin mRel = mValid; mValid = 0; mPh = 0; mCnt = 0; end
             else mCnt++;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    #1;
    if (keyPress) pressSeen++;
    if (keyRelease) relSeen++;
    check(rowOut == expRows(), "R1/R3/R6/R8 rowOut", rowOut, expRows());
    check(keyPress == mPress[0], "R4/R5 keyPress", keyPress, mPress);
    check(keyRelease == mRel[0], "R7 keyRelease", keyRelease, mRel);
    check(keyCode == mCode[4:0], "R4/R10 keyCode", keyCode, mCode);
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic keyDown(input int k); @(negedge clk); pressed[k] = 1'b1; endtask
  task automatic keyUp(input int k);   @(negedge clk); pressed[k] = 1'b0; endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, r0;
    cycles(3);
    #2;
    check(keyCode == 0 && !keyPress && !keyRelease, "R11 reset outputs", keyCode, 0);
    check(rowOut == '1, "R11 reset rows", rowOut, 5'h1f);
    @(negedge clk); rstN = 1'b1;

    // R1 R4 R7: dial key '6' (row 1, col 2 -> code 6)
    p0 = pressSeen; r0 = relSeen;
    keyDown(6); cycles(30); keyUp(6); cycles(30);
    check(pressSeen == p0 + 1, "R4 single tap press", pressSeen, p0 + 1);
    check(keyCode == 6, "R1 dial code", keyCode, 6);
    check(relSeen == r0 + 1, "R7 release after tap", relSeen, r0 + 1);

    // R1: function key in row 4, col 1 -> code 17
    keyDown(17); cycles(30); keyUp(17); cycles(30);
    check(keyCode == 17, "R1 function key code", keyCode, 17);

    // R2: contact shorter than debounce
    p0 = pressSeen;
    keyDown(2); cycles(DEB-3); keyUp(2); cycles(20);
    check(pressSeen == p0, "R2 short contact ignored", pressSeen, p0);
    // R2: pattern changes during debounce
    keyDown(1); cycles(3); keyUp(1); keyDown(2); cycles(30); keyUp(2); cycles(30);
    check(pressSeen == p0 + 1, "R2 pattern restart", pressSeen, p0 + 1);
    check(keyCode == 2, "R2 code after restart", keyCode, 2);

    // R5: two keys in one column, then two in one row
    p0 = pressSeen; r0 = relSeen;
    keyDown(0); pressed[4] = 1'b1; cycles(30); keyUp(0); pressed[4] = 1'b0; cycles(30);
    keyDown(8); pressed[9] = 1'b1; cycles(30); keyUp(8); pressed[9] = 1'b0; cycles(30);
    check(pressSeen == p0, "R5 no press for multi-key", pressSeen, p0);
    check(relSeen == r0, "R5 no release for multi-key", relSeen, r0);
    check(keyCode == 2, "R5 code kept", keyCode, 2);

    // R6: bounce during release, key held keeps block from rescanning
    p0 = pressSeen; r0 = relSeen;
    keyDown(9); cycles(30); keyUp(9); cycles(DEB-3); keyDown(9); cycles(40);
    check(relSeen == r0, "R6 release restarted", relSeen, r0);
    check(pressSeen == p0 + 1, "R6 no rescan while held", pressSeen, p0 + 1);
    keyUp(9); cycles(30);
    check(relSeen == r0 + 1, "R6 release after quiet", relSeen, r0 + 1);

    // R9: short standby during press debounce
    p0 = pressSeen;
    keyDown(10); cycles(3);
    @(negedge clk); chipEn = 1'b0; cycles(RSTD-2);
    @(negedge clk); chipEn = 1'b1; cycles(30);
    check(pressSeen == p0 + 1, "R9 short standby harmless", pressSeen, p0 + 1);
    check(keyCode == 10, "R9 code", keyCode, 10);
    keyUp(10); cycles(30);

    // R8: keypad ignored in standby
    p0 = pressSeen;
    @(negedge clk); chipEn = 1'b0; pressed[11] = 1'b1; cycles(10);
    check(rowOut == 0, "R8 rows released", rowOut, 0);
    pressed[11] = 1'b0;
    @(negedge clk); chipEn = 1'b1; cycles(30);
    check(pressSeen == p0, "R8 no event in standby", pressSeen, p0);

    // R10: long standby while a key is held
    p0 = pressSeen; r0 = relSeen;
    keyDown(12); cycles(30);
    @(negedge clk); chipEn = 1'b0; cycles(RSTD + 4);
    pressed[12] = 1'b0;
    @(negedge clk); chipEn = 1'b1; cycles(30);
    check(pressSeen == p0 + 1, "R10 press before standby", pressSeen, p0 + 1);
    check(relSeen == r0, "R10 pending release dropped", relSeen, r0);
    check(keyCode == 0, "R10 code cleared", keyCode, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule